// File: doc/BRIEF.md
# I2C 10-bit slave address matcher

This block follows the address phase of an I2C slave that answers to a 10-bit address and decides, byte by byte, whether the slave should acknowledge. A bit-level front end, not part of this block, turns the bus into single-cycle events:
- start and repeated start;
- stop;
- a received byte with its value;
- the master's acknowledge or not-acknowledge after a byte the slave transmitted.

The configured 10-bit own address is a plain input.

The matcher raises a one-cycle acknowledge request for every byte that the slave must acknowledge. It keeps an addressed flag and a direction flag that tells the front end whether the slave is now a transmitter.

A write transfer is addressed by a header byte followed by the low address byte. A read transfer is reached by first sending the full write-form address, then a repeated start, then the header byte with the read bit set. The block remembers explicitly that a full 10-bit write address has matched. Because of this, a header-with-read byte only counts directly after a repeated start. It is never recognised inside data, and no data value of an earlier transfer can disturb the addressing of a later one.

Top module: `i2c10_addr_match`

## Requirements
- R1: After reset, ack_req, addressed and slave_tx are all 0.
- R2: The first byte after a start is acknowledged when bits 7:3 equal 5'b11110, bits 2:1 equal own_addr[9:8], and bit 0 (R/W) is 0. For own address 0x2AA this byte is 0xF4. A first byte whose bits 7:3 or bits 2:1 differ is not acknowledged.
- R3: After an acknowledged header, a byte equal to own_addr[7:0] is acknowledged and sets addressed=1 and slave_tx=0. A different byte is not acknowledged and leaves both flags unchanged. The flags change only on acknowledged address bytes and on stop.
- R4: While addressed as a receiver, every data byte is acknowledged and leaves the flags unchanged. This includes a byte equal to the read-form header, 0xF5 for own address 0x2AA.
- R5: After a full write-address match, a repeated start followed by the header with bit 0 = 1 is acknowledged and sets addressed=1 and slave_tx=1.
- R6: A read-form header is not acknowledged after a plain start, or after a repeated start when no full write address has matched since the last stop or mismatch.
- R7: A stop clears addressed, slave_tx and the matched context. A later repeated start followed by a read header is then not acknowledged.
- R8: A second read transfer to the same slave, following a stop, is acknowledged exactly like the first.
- R9: A last data byte whose low nibble is 0xF (for example 0x0F) does not prevent the next transfer's address bytes from being acknowledged.
- R10: While the slave transmits, bytes and master acknowledge or not-acknowledge events never raise ack_req.
- R11: After an address mismatch, no byte is acknowledged until the next start or repeated start.
- R12: ack_req is high for exactly the one cycle after the clock edge that samples the byte event being acknowledged.
- R13: When events coincide in one cycle, stop takes precedence over start, start over repeated start, and repeated start over a byte. A byte arriving with a stop is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 10 | Configured 10-bit slave address |
| ev_start | input | 1 | Start condition seen (one cycle) |
| ev_rstart | input | 1 | Repeated start seen (one cycle) |
| ev_stop | input | 1 | Stop condition seen (one cycle) |
| ev_byte | input | 1 | A full byte was received (one cycle) |
| rx_byte | input | 8 | Value of the received byte, valid with ev_byte |
| ev_mack | input | 1 | Master acknowledge slot after a transmitted byte |
| mack_nack | input | 1 | With ev_mack: 1 = master did not acknowledge |
| ack_req | output | 1 | Slave must acknowledge the byte just received |
| addressed | output | 1 | Slave is currently addressed |
| slave_tx | output | 1 | Slave is transmitter (read transfer) |

## Verification
The bench uses the default header tag 5'b11110 and leaves data acknowledge enabled. With those values, write transfers, read transfers through a repeated start and back-to-back transfers behave as a standard slave would. The own address is a port, so one run covers 0x2AA and also switches to 0x1AA. This puts both address-bit combinations on the header comparison. It also reaches the corner cases that matter most: the read-form header sent as write data, a last data byte ending in 0xF, and a read header after a mismatch or a stop.

// File: rtl/i2c10_addr_match.sv
module i2c10_addr_match #(
  parameter logic [4:0] HDR_TAG     = 5'b11110,
  parameter bit         ACK_WR_DATA = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] own_addr,
  input  logic       ev_start,
  input  logic       ev_rstart,
  input  logic       ev_stop,
  input  logic       ev_byte,
  input  logic [7:0] rx_byte,
  input  logic       ev_mack,
  input  logic       mack_nack,
  output logic       ack_req,
  output logic       addressed,
  output logic       slave_tx
);

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_LOW, S_RHDR, S_RX, S_TX, S_SKIP
  } st_t;

  st_t  st, st_n;
  logic ctx, ctx_n;
  logic ack_n, addr_n, tx_n;

  logic hdr_hit, hdr_wr, hdr_rd, low_hit;

  assign hdr_hit = (rx_byte[7:3] == HDR_TAG) && (rx_byte[2:1] == own_addr[9:8]);
  assign hdr_wr  = hdr_hit && !rx_byte[0];
  assign hdr_rd  = hdr_hit &&  rx_byte[0];
  assign low_hit = (rx_byte == own_addr[7:0]);

  always_comb begin
    st_n   = st;
    ctx_n  = ctx;
    ack_n  = 1'b0;
    addr_n = addressed;
    tx_n   = slave_tx;
    if (ev_stop) begin
      st_n   = S_IDLE;
      ctx_n  = 1'b0;
      addr_n = 1'b0;
      tx_n   = 1'b0;
    end else if (ev_start) begin
      st_n = S_HDR;
    end else if (ev_rstart) begin
      st_n = ctx ? S_RHDR : S_HDR;
    end else if (ev_byte) begin
      unique case (st)
        S_HDR: begin
          ctx_n = 1'b0;
          if (hdr_wr) begin
            st_n  = S_LOW;
            ack_n = 1'b1;
          end else begin
            st_n = S_SKIP;
          end
        end
        S_RHDR: begin
          if (hdr_rd) begin
            st_n   = S_TX;
            ack_n  = 1'b1;
            addr_n = 1'b1;
            tx_n   = 1'b1;
          end else if (hdr_wr) begin
            st_n  = S_LOW;
            ack_n = 1'b1;
            ctx_n = 1'b0;
          end else begin
            st_n  = S_SKIP;
            ctx_n = 1'b0;
          end
        end
        S_LOW: begin
          if (low_hit) begin
            st_n   = S_RX;
            ack_n  = 1'b1;
            ctx_n  = 1'b1;
            addr_n = 1'b1;
            tx_n   = 1'b0;
          end else begin
            st_n = S_SKIP;
          end
        end
        S_RX:    ack_n = ACK_WR_DATA;
        default: ;
      endcase
    end else if (ev_mack && mack_nack && st == S_TX) begin
      st_n = S_SKIP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ctx       <= 1'b0;
      ack_req   <= 1'b0;
      addressed <= 1'b0;
      slave_tx  <= 1'b0;
    end else begin
      st        <= st_n;
      ctx       <= ctx_n;
      ack_req   <= ack_n;
      addressed <= addr_n;
      slave_tx  <= tx_n;
    end
  end

endmodule

// File: rtl/i2c10_addr_match_chk.sv
module i2c10_addr_match_chk (
  input logic clk,
  input logic rst_n,
  input logic ev_start,
  input logic ev_rstart,
  input logic ev_stop,
  input logic ev_byte,
  input logic ev_mack,
  input logic ack_req,
  input logic addressed,
  input logic slave_tx
);

  AST_ACK_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req) |-> $past(ev_byte)); // R12

  AST_ACK_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ev_byte) |=> !ack_req); // R12

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!addressed && !slave_tx && !ack_req)); // R7

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_byte && !ev_stop) |=> ($stable(addressed) && $stable(slave_tx))); // R3

  AST_ADDR_RISE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed) |-> ack_req); // R3

  AST_TX_RISE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slave_tx) |-> (ack_req && addressed)); // R5

  AST_TX_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    slave_tx |-> addressed); // R5

  AST_EVENT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop || ev_start || ev_rstart || ev_mack) && !ev_byte |=> !ack_req); // R13

endmodule

bind i2c10_addr_match i2c10_addr_match_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_start  (ev_start),
  .ev_rstart (ev_rstart),
  .ev_stop   (ev_stop),
  .ev_byte   (ev_byte),
  .ev_mack   (ev_mack),
  .ack_req   (ack_req),
  .addressed (addressed),
  .slave_tx  (slave_tx)
);

// File: tb/tb_i2c10_addr_match.sv
`timescale 1ns/1ps
module tb_i2c10_addr_match;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] own_addr = 10'h2AA;
  logic       ev_start = 1'b0, ev_rstart = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       ev_mack = 1'b0, mack_nack = 1'b0;
  logic       ack_req, addressed, slave_tx;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  i2c10_addr_match dut (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr),
    .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop),
    .ev_byte(ev_byte), .rx_byte(rx_byte), .ev_mack(ev_mack), .mack_nack(mack_nack),
    .ack_req(ack_req), .addressed(addressed), .slave_tx(slave_tx)
  );

  localparam logic [2:0] ST = 3'd0, RS = 3'd1, BY = 3'd2, SP = 3'd3, MA = 3'd4, MN = 3'd5;
  localparam int NV = 54;
  // {op, byte, ack, addressed, slave_tx, requirement}
  localparam logic [17:0] VEC [NV] = '{
    {ST, 8'h00, 3'b000, 4'd2},
    {BY, 8'hF4, 3'b100, 4'd2},   // R2 header write
    {BY, 8'hAA, 3'b110, 4'd3},   // R3 low byte
    {BY, 8'hF5, 3'b110, 4'd4},   // R4 read-form header as data
    {BY, 8'h0F, 3'b110, 4'd9},   // R9 data ending in F
    {SP, 8'h00, 3'b000, 4'd7},   // R7
    {ST, 8'h00, 3'b000, 4'd9},
    {BY, 8'hF4, 3'b100, 4'd9},   // R9 next address still acked
    {BY, 8'hAA, 3'b110, 4'd9},
    {RS, 8'h00, 3'b010, 4'd5},
    {BY, 8'hF5, 3'b111, 4'd5},   // R5 read header
    {BY, 8'h3C, 3'b011, 4'd10},  // R10 no ack while tx
    {MA, 8'h00, 3'b011, 4'd10},
    {BY, 8'hF5, 3'b011, 4'd10},
    {MN, 8'h00, 3'b011, 4'd10},
    {SP, 8'h00, 3'b000, 4'd7},
    {ST, 8'h00, 3'b000, 4'd8},
    {BY, 8'hF4, 3'b100, 4'd8},
    {BY, 8'hAA, 3'b110, 4'd8},
    {RS, 8'h00, 3'b010, 4'd8},
    {BY, 8'hF5, 3'b111, 4'd8},   // R8 second read
    {SP, 8'h00, 3'b000, 4'd8},
    {ST, 8'h00, 3'b000, 4'd6},
    {BY, 8'hF5, 3'b000, 4'd6},   // R6 read header after plain start
    {BY, 8'h55, 3'b000, 4'd11},  // R11
    {SP, 8'h00, 3'b000, 4'd11},
    {ST, 8'h00, 3'b000, 4'd2},
    {BY, 8'hF6, 3'b000, 4'd2},   // R2 bits 9:8 differ
    {BY, 8'hAA, 3'b000, 4'd11},  // R11
    {SP, 8'h00, 3'b000, 4'd2},
    {ST, 8'h00, 3'b000, 4'd2},
    {BY, 8'hE4, 3'b000, 4'd2},   // R2 tag differs
    {SP, 8'h00, 3'b000, 4'd2},
    {ST, 8'h00, 3'b000, 4'd3},
    {BY, 8'hF4, 3'b100, 4'd3},
    {BY, 8'hAB, 3'b000, 4'd3},   // R3 low mismatch
    {RS, 8'h00, 3'b000, 4'd6},
    {BY, 8'hF5, 3'b000, 4'd6},   // R6 no context
    {SP, 8'h00, 3'b000, 4'd6},
    {ST, 8'h00, 3'b000, 4'd7},
    {BY, 8'hF4, 3'b100, 4'd7},
    {BY, 8'hAA, 3'b110, 4'd7},
    {SP, 8'h00, 3'b000, 4'd7},
    {RS, 8'h00, 3'b000, 4'd7},
    {BY, 8'hF5, 3'b000, 4'd7},   // R7 context cleared by stop
    {SP, 8'h00, 3'b000, 4'd7},
    {ST, 8'h00, 3'b000, 4'd3},
    {BY, 8'hF4, 3'b100, 4'd3},
    {BY, 8'hAA, 3'b110, 4'd3},
    {ST, 8'h00, 3'b010, 4'd3},   // new start keeps flags
    {BY, 8'hF4, 3'b110, 4'd3},
    {BY, 8'h12, 3'b010, 4'd3},   // R3 mismatch keeps flags
    {BY, 8'h34, 3'b010, 4'd11},  // R11
    {SP, 8'h00, 3'b000, 4'd7}
  };

  task automatic check3(input int req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: {ack,addr,tx} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [7:0] b);
    ev_start  = (op == ST);
    ev_rstart = (op == RS);
    ev_stop   = (op == SP);
    ev_byte   = (op == BY);
    ev_mack   = (op == MA) || (op == MN);
    mack_nack = (op == MN);
    rx_byte   = b;
  endtask

  task automatic idle();
    drive(3'd7, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    check3(1, {ack_req, addressed, slave_tx}, 3'b000);   // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check3(1, {ack_req, addressed, slave_tx}, 3'b000);   // R1 after release

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][17:15], VEC[i][14:7]);
      @(negedge clk);
      idle();
      check3(int'(VEC[i][3:0]), {ack_req, addressed, slave_tx}, VEC[i][6:4]);
    end

    // R12: pulse lasts one cycle
    drive(ST, 8'h00); @(negedge clk);
    drive(BY, 8'hF4); @(negedge clk); idle();
    check3(12, {ack_req, addressed, slave_tx}, 3'b100);
    @(negedge clk);
    check3(12, {ack_req, addressed, slave_tx}, 3'b000);

    // R13: stop together with a byte wins
    drive(BY, 8'hAA); ev_stop = 1'b1; @(negedge clk); idle();
    check3(13, {ack_req, addressed, slave_tx}, 3'b000);
    // R13: start together with a byte: byte ignored, then header still accepted
    drive(BY, 8'hF4); ev_start = 1'b1; @(negedge clk); idle();
    check3(13, {ack_req, addressed, slave_tx}, 3'b000);
    drive(BY, 8'hF4); @(negedge clk); idle();
    check3(13, {ack_req, addressed, slave_tx}, 3'b100);
    drive(SP, 8'h00); @(negedge clk); idle();

    // R2 / R5: other address 0x1AA, header 0xF2 / 0xF3
    own_addr = 10'h1AA;
    drive(ST, 8'h00); @(negedge clk);
    drive(BY, 8'hF4); @(negedge clk); idle();
    check3(2, {ack_req, addressed, slave_tx}, 3'b000);
    drive(ST, 8'h00); @(negedge clk);
    drive(BY, 8'hF2); @(negedge clk); idle();
    check3(2, {ack_req, addressed, slave_tx}, 3'b100);
    drive(BY, 8'hAA); @(negedge clk); idle();
    check3(3, {ack_req, addressed, slave_tx}, 3'b110);
    drive(BY, 8'hF3); @(negedge clk); idle();
    check3(4, {ack_req, addressed, slave_tx}, 3'b110);
    drive(RS, 8'h00); @(negedge clk);
    drive(BY, 8'hF3); @(negedge clk); idle();
    check3(5, {ack_req, addressed, slave_tx}, 3'b111);

    // R1: reset mid-transfer
    rst_n = 1'b0; @(negedge clk);
    check3(1, {ack_req, addressed, slave_tx}, 3'b000);
    rst_n = 1'b1; @(negedge clk);
    drive(RS, 8'h00); @(negedge clk);
    drive(BY, 8'hF3); @(negedge clk); idle();
    check3(6, {ack_req, addressed, slave_tx}, 3'b000);   // R6 context lost by reset

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule